// File: doc/BRIEF.md
# MSI multi-vector message generator

This block turns interrupt events from up to 32 sources into message-signalled interrupt writes. Software programs, through a small register port, an enable bit, the number of vectors it grants (as a power of two), one message address of 32 or 64 bits, a 16-bit base data value and an optional per-vector mask. When a source fires, the block maps it to a granted vector and records it as pending. A small controller then picks the lowest-numbered pending vector that is unmasked and issues one posted write request for it. The request carries the shared address and the base data with its low bits replaced by the vector number. Masked vectors stay pending until software unmasks them. The write request uses a valid/ready handshake, and packet formatting is left to the logic downstream.

The controller has two states. In `ST_IDLE` the block is waiting. The transition `pick` goes from `ST_IDLE` to `ST_SEND` when the enable bit is set and an eligible vector exists. On `pick` the address, the data word and the vector are latched. In `ST_SEND` the block offers the request. The transition `accept` goes from `ST_SEND` back to `ST_IDLE` on the handshake and clears the vector's pending bit. `ST_SEND` holds while ready is low.

Register offsets on `reg_addr` are:
- 0: control
- 1: address low
- 2: address high
- 3: base data
- 4: mask
- 5: pending

Top module: `msi_msg_gen`

## Requirements
- R1: After reset the control register reads 0x18A with default parameters: bit 0 enable = 0, bits 3:1 requested log2 count = 5, bits 6:4 granted log2 count = 0, bit 7 64-bit capable = 1, bit 8 mask capable = 1. Pending reads 0 and `wr_valid` is low.
- R2: A write to the granted field (control bits 6:4) that exceeds the requested log2 count is stored as the requested count. The field never exceeds it.
- R3: With G granted (log2), the write data equals the base data with its low G bits replaced by the vector number. For example, base 0x0040 with G=3 gives 0x0045 for vector 5.
- R4: A source index at or above 2^G is sent as vector 2^G-1. With G=0 every source uses vector 0. No data word ever carries a vector outside the granted range.
- R5: Every write uses the single programmed address, with the low two bits zero. `wr_is64` is 1 exactly when the address-high register is nonzero. That register reads 0 and ignores writes when 64-bit capability is off.
- R6: A source that fires while its vector is masked sets that vector's pending bit (pending register bit N = vector N) and produces no write.
- R7: When a pending vector is unmasked, one write for it is issued and its pending bit is cleared.
- R8: Pending bits are read-only. Writes to offset 5 change nothing.
- R9: While enable is 0, source events are dropped (no pending bit is set) and no write is started.
- R10: When several vectors are eligible, the lowest-numbered is sent first. Each handshake delivers exactly one vector.
- R11: Once `wr_valid` is high, it stays high with stable address and data until `wr_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| src_req | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Message address |
| wr_is64 | output | 1 | Address needs 64-bit form |
| wr_data | output | 16 | Message data |

## Verification
The assertions check on every cycle the following properties:
- The granted count stays within the requested count.
- A new request never starts while disabled or for a vector that was masked when it was picked.
- The data word keeps the base bits above the granted field.
- The request stays stable under backpressure.

Only the bench's scenarios can show the rest:
- Folding of out-of-range sources onto the top vector.
- Service order across several pending vectors.
- Delivery and clearing after an unmask.
- That dropped and read-only cases leave the pending register untouched.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int MAX_VEC = 32;
    localparam int VEC_W   = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } msi_state_t;

    localparam logic [2:0] OFF_CTRL  = 3'd0;
    localparam logic [2:0] OFF_ADDRL = 3'd1;
    localparam logic [2:0] OFF_ADDRH = 3'd2;
    localparam logic [2:0] OFF_DATA  = 3'd3;
    localparam logic [2:0] OFF_MASK  = 3'd4;
    localparam logic [2:0] OFF_PEND  = 3'd5;

    // Bit set covering the 2^g granted vectors
    function automatic logic [MAX_VEC-1:0] granted_set(input logic [2:0] g);
        logic [MAX_VEC:0] t;
        t = ({{MAX_VEC{1'b0}}, 1'b1} << (1 << g)) - 1'b1;
        return t[MAX_VEC-1:0];
    endfunction
endpackage

// File: rtl/msi_regs.sv
module msi_regs
    import msi_pkg::*;
#(
    parameter int REQ_LOG2   = 5,
    parameter bit ADDR64_CAP = 1'b1,
    parameter bit MASK_CAP   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [MAX_VEC-1:0] pend_set,
    input  logic [MAX_VEC-1:0] pend_clr,
    output logic               en,
    output logic [2:0]         grant,
    output logic [63:0]        addr,
    output logic [15:0]        base,
    output logic [MAX_VEC-1:0] mask,
    output logic [MAX_VEC-1:0] pend
);
    localparam logic [2:0] REQ3 = 3'(REQ_LOG2);

    logic [31:0] addr_lo, addr_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            grant   <= 3'd0;
            addr_lo <= '0;
            addr_hi <= '0;
            base    <= '0;
            mask    <= '0;
            pend    <= '0;
        end else begin
            pend <= (pend & ~pend_clr) | pend_set;
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_CTRL: begin
                        en    <= reg_wdata[0];
                        grant <= (reg_wdata[6:4] > REQ3) ? REQ3 : reg_wdata[6:4];
                    end
                    OFF_ADDRL: addr_lo <= {reg_wdata[31:2], 2'b00};
                    OFF_ADDRH: if (ADDR64_CAP) addr_hi <= reg_wdata;
                    OFF_DATA:  base <= reg_wdata[15:0];
                    OFF_MASK:  if (MASK_CAP) mask <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    assign addr = {addr_hi, addr_lo};

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL:  reg_rdata = {23'd0, MASK_CAP, ADDR64_CAP, grant, REQ3, en};
            OFF_ADDRL: reg_rdata = addr_lo;
            OFF_ADDRH: reg_rdata = addr_hi;
            OFF_DATA:  reg_rdata = {16'd0, base};
            OFF_MASK:  reg_rdata = mask;
            OFF_PEND:  reg_rdata = pend;
            default:   reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/msi_vec_map.sv
module msi_vec_map
    import msi_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [2:0]         grant,
    output logic [MAX_VEC-1:0] hit
);
    int top;

    always_comb begin
        top = (1 << grant) - 1;
        hit = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_req[s]) begin
                if (s > top) hit[VEC_W'(top)] = 1'b1;
                else         hit[VEC_W'(s)]   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_arbiter.sv
module msi_arbiter
    import msi_pkg::*;
(
    input  logic [MAX_VEC-1:0] req,
    output logic               any,
    output logic [VEC_W-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = MAX_VEC - 1; i >= 0; i--) begin
            if (req[i]) idx = VEC_W'(i);
        end
    end
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
    import msi_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int REQ_LOG2   = 5,
    parameter bit ADDR64_CAP = 1'b1,
    parameter bit MASK_CAP   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [63:0]        wr_addr,
    output logic               wr_is64,
    output logic [15:0]        wr_data
);
    logic               en_w;
    logic [2:0]         grant_w;
    logic [63:0]        addr_w;
    logic [15:0]        base_w;
    logic [MAX_VEC-1:0] mask_w, pend_w, hit_w, pend_set, pend_clr, elig;
    logic               any_w;
    logic [VEC_W-1:0]   pick_w;

    msi_state_t       state, state_n;
    logic [VEC_W-1:0] vec_q;
    logic [15:0]      data_q;
    logic [63:0]      addr_q;
    logic [15:0]      low_w;

    msi_regs #(
        .REQ_LOG2  (REQ_LOG2),
        .ADDR64_CAP(ADDR64_CAP),
        .MASK_CAP  (MASK_CAP)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .en       (en_w),
        .grant    (grant_w),
        .addr     (addr_w),
        .base     (base_w),
        .mask     (mask_w),
        .pend     (pend_w)
    );

    msi_vec_map #(.NUM_SRC(NUM_SRC)) u_map (
        .src_req(src_req),
        .grant  (grant_w),
        .hit    (hit_w)
    );

    assign pend_set = en_w ? hit_w : '0;
    assign elig     = pend_w & ~mask_w & granted_set(grant_w);

    msi_arbiter u_arb (
        .req(elig),
        .any(any_w),
        .idx(pick_w)
    );

    assign low_w = 16'((1 << grant_w) - 1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Payload latched on pick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
        end else if (state == ST_IDLE && en_w && any_w) begin
            vec_q  <= pick_w;
            data_q <= (base_w & ~low_w) | (16'(pick_w) & low_w);
            addr_q <= addr_w;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n  = state;
        wr_valid = 1'b0;
        pend_clr = '0;
        unique case (state)
            ST_IDLE: begin
                if (en_w && any_w) state_n = ST_SEND;
            end
            ST_SEND: begin
                wr_valid = 1'b1;
                if (wr_ready) begin
                    pend_clr[vec_q] = 1'b1;
                    state_n         = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign wr_is64 = |addr_q[63:32];
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk
    import msi_pkg::*;
#(
    parameter int REQ_LOG2 = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [63:0]        wr_addr,
    input logic [15:0]        wr_data,
    input logic               en,
    input logic [2:0]         grant,
    input logic [15:0]        base,
    input logic [MAX_VEC-1:0] mask
);
    logic               en_d;
    logic [2:0]         grant_d;
    logic [15:0]        base_d, low_d;
    logic [MAX_VEC-1:0] mask_d;
    logic [VEC_W-1:0]   sent_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d    <= 1'b0;
            grant_d <= 3'd0;
            base_d  <= '0;
            mask_d  <= '0;
        end else begin
            en_d    <= en;
            grant_d <= grant;
            base_d  <= base;
            mask_d  <= mask;
        end
    end

    assign low_d    = 16'((1 << grant_d) - 1);
    assign sent_vec = VEC_W'(wr_data & low_d);

    AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant <= 3'(REQ_LOG2));                                                   // R2
    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> ((wr_data ^ base_d) & ~low_d) == 16'd0);              // R3
    AST_NO_SEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> !mask_d[sent_vec]);                                   // R6
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> en_d);                                                // R9
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr))); // R11
endmodule

bind msi_msg_gen msi_msg_gen_chk #(.REQ_LOG2(REQ_LOG2)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en      (en_w),
    .grant   (grant_w),
    .base    (base_w),
    .mask    (mask_w)
);

// File: tb/test_msi_msg_gen.sv
module test_msi_msg_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] src_req = 32'd0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [63:0] wr_addr;
    logic        wr_is64;
    logic [15:0] wr_data;

    int total = 0;
    int bad = 0;
    int ncap = 0;
    logic [15:0] cap_d [64];
    logic [63:0] cap_a [64];
    logic        cap64 [64];

    always #10 clk = ~clk;

    msi_msg_gen i_msi_msg_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_is64(wr_is64), .wr_data(wr_data)
    );

    // Record each completed handshake
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready && ncap < 64) begin
            cap_d[ncap] = wr_data;
            cap_a[ncap] = wr_addr;
            cap64[ncap] = wr_is64;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk);
        src_req = s;
        @(negedge clk);
        src_req = 32'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int fold(input int g, input int s);
        int top;
        top = (1 << g) - 1;
        return (s > top) ? top : s;
    endfunction

    function automatic logic [15:0] exp_data(input logic [15:0] b, input int g, input int s);
        logic [15:0] low;
        low = 16'((1 << g) - 1);
        return (b & ~low) | (16'(fold(g, s)) & low);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        rreg(3'd0, r); check(r == 32'h18A, "R1 ctrl", r, 32'h18A);
        rreg(3'd5, r); check(r == 32'h0, "R1 pend", r, 0);
        check(wr_valid == 1'b0, "R1 valid", wr_valid, 0);

        // R2: granted clamp
        wreg(3'd0, 32'h70);
        rreg(3'd0, r); check(r[6:4] == 3'd5, "R2 clamp", r[6:4], 5);

        // R9: disabled drops events
        wreg(3'd0, 32'h30);
        ncap = 0; pulse(32'h8); idle(6);
        check(ncap == 0, "R9 no write", ncap, 0);
        rreg(3'd5, r); check(r == 0, "R9 no pending", r, 0);

        // R3 / R5: example encoding and address
        wreg(3'd1, 32'hFEE0_0003);
        wreg(3'd3, 32'h0040);
        wreg(3'd0, 32'h31);
        ncap = 0; pulse(32'h20); idle(6);
        check(ncap == 1 && cap_d[0] == 16'h0045, "R3 vec5", cap_d[0], 16'h0045);
        check(cap_a[0] == 64'hFEE0_0000 && !cap64[0], "R5 addr32", cap_a[0], 64'hFEE0_0000);

        // R4: fold above range, and single vector
        ncap = 0; pulse(32'h0010_0000); idle(6);
        check(ncap == 1 && cap_d[0] == 16'h0047, "R4 fold top", cap_d[0], 16'h0047);
        wreg(3'd0, 32'h01);
        ncap = 0; pulse(32'h200); idle(6);
        check(ncap == 1 && cap_d[0] == 16'h0040, "R4 single", cap_d[0], 16'h0040);

        // R5: 64-bit address
        wreg(3'd2, 32'h1);
        ncap = 0; pulse(32'h1); idle(6);
        check(cap_a[0] == 64'h1_FEE0_0000 && cap64[0], "R5 addr64", cap_a[0], 64'h1_FEE0_0000);
        wreg(3'd2, 32'h0);

        // R6 / R8 / R10 / R7: masked pending, read-only, order after unmask
        wreg(3'd0, 32'h31);
        wreg(3'd4, 32'hFFFF_FFFF);
        ncap = 0; pulse(32'h54); idle(6);
        check(ncap == 0, "R6 masked no write", ncap, 0);
        rreg(3'd5, r); check(r == 32'h54, "R6 pending", r, 32'h54);
        wreg(3'd5, 32'h0);
        rreg(3'd5, r); check(r == 32'h54, "R8 read-only", r, 32'h54);
        wreg(3'd4, 32'h0); idle(10);
        check(ncap == 3, "R10 count", ncap, 3);
        check(cap_d[0] == 16'h42 && cap_d[1] == 16'h44 && cap_d[2] == 16'h46,
              "R10 order", {cap_d[0], cap_d[1], cap_d[2]}, 48'h0042_0044_0046);
        rreg(3'd5, r); check(r == 0, "R7 cleared", r, 0);

        // R11: backpressure
        @(negedge clk) wr_ready = 1'b0;
        ncap = 0; pulse(32'h2); idle(5);
        check(wr_valid && wr_data == 16'h41, "R11 hold", wr_data, 16'h41);
        @(negedge clk) wr_ready = 1'b1;
        idle(3);
        check(ncap == 1, "R11 one write", ncap, 1);

        // Random: R3 R4 R6 R7
        for (int it = 0; it < 40; it++) begin
            int g, s, v;
            logic [15:0] b;
            bit m;
            g = $urandom % 6; s = $urandom % 32; b = 16'($urandom); m = ($urandom % 2) == 1;
            v = fold(g, s);
            wreg(3'd3, {16'd0, b});
            wreg(3'd0, 32'((g << 4) | 1));
            wreg(3'd4, m ? (32'd1 << v) : 32'd0);
            ncap = 0; pulse(32'd1 << s); idle(6);
            if (m) begin
                check(ncap == 0, "R6 rand", ncap, 0);
                rreg(3'd5, r); check(r == (32'd1 << v), "R6 rand pend", r, 32'd1 << v);
                wreg(3'd4, 32'd0); idle(6);
            end
            check(ncap == 1 && cap_d[0] == exp_data(b, g, s), "R4 rand data", cap_d[0], exp_data(b, g, s));
            rreg(3'd5, r); check(r == 0, "R7 rand clear", r, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule